// File: doc/BRIEF.md
# Two-Page Transceiver Management Memory

This block is the byte-addressed register space that a pluggable optical module shows to its host over a two-wire management bus. The bit-level serial engine sits outside it. That engine opens a transaction by pulsing `xfer_start` with a device address and a starting offset. It then issues read or write strobes, one byte per strobe. The offset steps forward by one after every byte. Two device addresses exist: 0xA0 selects the identification page and 0xA2 selects the diagnostics page.

Fixed content is produced by a formula. It stands in for non-volatile storage. The block also holds:
- a 120-byte user area on the diagnostics page,
- five live 16-bit measurement words, loaded by the monitoring logic through a separate update port,
- three check bytes that are always computed in hardware.

A read of the high byte of a measurement word latches the low byte in the same cycle. This keeps an MSB-first sequential read of the pair coherent while the live value keeps changing.

Top module: `xcvr_mgmt_mem`

## Requirements
- R1: Outside the special offsets, a byte at offset `o` of page `p` reads as (7*o + 0x35*p + SEED) mod 256. Here p=0 is the identification page (device 0xA0), p=1 is the diagnostics page (device 0xA2), and SEED defaults to 0x11.
- R2: Identification offset 92 reads with bit 6 set and bits 3..0 clear. Bit 5 is set when CAL_INTERNAL=1 and bit 4 is set when CAL_INTERNAL=0, giving 0x60 with the default parameters.
- R3: Identification offset 63 reads as the low 8 bits of the sum of identification bytes 0..62. Identification offset 95 reads as the low 8 bits of the sum of identification bytes 64..94, with byte 92 counted as its R2 value.
- R4: Diagnostics offset 95 reads as the low 8 bits of the sum of diagnostics bytes 0..94.
- R5: Diagnostics offsets 96..105 hold five 16-bit words in this order: temperature, supply voltage, TX bias, TX power, RX power. Each word sits high byte first. An update strobe with index k (0..4) replaces word k.
- R6: A read of a word's high byte latches its low byte. The next read of that low byte in the same transaction returns the latched value, even if the word was updated in between. A low-byte read without a preceding high-byte read in the transaction returns the live value.
- R7: Diagnostics offsets 128..247 are writable storage, and each byte reads back what was last written to it. They read 0x00 after reset.
- R8: Writes to any other offset of either page leave the read value unchanged, including the offsets next to the user area (127 and 248).
- R9: A write to a check-byte offset (identification 63 or 95, diagnostics 95) does not change the value that offset reads.
- R10: Within a transaction, the offset advances by one after each read or write and wraps from 255 to 0.
- R11: With any device address other than 0xA0 or 0xA2, and before the first transaction after reset, reads return 0xFF and writes change nothing.
- R12: `rd_valid` is high exactly in the cycle after a read strobe, and `rd_byte` holds the byte read at that time. After reset both are 0.
- R13: An update strobe with an index of 5 or above changes no measurement word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Opens a transaction; loads the page select and the offset |
| dev_sel | input | 8 | Device address presented with `xfer_start` |
| start_off | input | 8 | Starting byte offset presented with `xfer_start` |
| rd_en | input | 1 | Read one byte at the current offset |
| wr_en | input | 1 | Write one byte at the current offset (ignored while `rd_en` is high) |
| wr_byte | input | 8 | Write data |
| rd_byte | output | 8 | Read data, registered |
| rd_valid | output | 1 | `rd_byte` carries the result of the previous cycle's read |
| meas_we | input | 1 | Measurement update strobe |
| meas_idx | input | 3 | Index of the measurement word to update |
| meas_word | input | 16 | New measurement value |

## Verification
The hardest case to reach is a torn read: a measurement word changes between the high-byte and low-byte reads of one transaction. The bench sets this up on purpose. It reads the high byte, pulses the update port with a new value, and then reads the low byte. It expects the old low byte back. A fresh transaction that starts directly at the low byte must then return the new value. Pointer wrap-around and reads that cross the check bytes are reached by opening transactions near offset 255 and offset 95. Ignored writes are checked by reading the same offsets back afterwards.

// File: rtl/xcvr_mgmt_mem.sv
module xcvr_mgmt_mem #(
  parameter logic [7:0] SEED         = 8'h11,
  parameter bit         CAL_INTERNAL = 1'b1,
  parameter logic [7:0] ID_ADDR      = 8'hA0,
  parameter logic [7:0] DIAG_ADDR    = 8'hA2,
  parameter int         NUM_MEAS     = 5,
  parameter int         MEAS_BASE    = 96,
  parameter int         USER_LO      = 128,
  parameter int         USER_HI      = 247
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_start,
  input  logic [7:0]  dev_sel,
  input  logic [7:0]  start_off,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [7:0]  wr_byte,
  output logic [7:0]  rd_byte,
  output logic        rd_valid,
  input  logic        meas_we,
  input  logic [2:0]  meas_idx,
  input  logic [15:0] meas_word
);
  localparam int USER_N = USER_HI - USER_LO + 1;
  localparam int UW     = $clog2(USER_N);
  localparam logic [7:0] DTYPE = {1'b0, 1'b1, CAL_INTERNAL, ~CAL_INTERNAL, 4'b0000};

  function automatic logic [7:0] fixed_byte(input bit pg, input int off);
    logic [7:0] b;
    b = 8'(off * 7) + (pg ? 8'h35 : 8'h00) + SEED;
    if (!pg && off == 92) b = DTYPE;
    return b;
  endfunction

  function automatic logic [7:0] csum(input bit pg, input int lo, input int hi);
    logic [7:0] s;
    s = 8'h00;
    for (int i = lo; i <= hi; i++) s = s + fixed_byte(pg, i);
    return s;
  endfunction

  localparam logic [7:0] ID_CK_LO = csum(1'b0, 0, 62);
  localparam logic [7:0] ID_CK_HI = csum(1'b0, 64, 94);
  localparam logic [7:0] DG_CK    = csum(1'b1, 0, 94);

  logic [7:0]  ptr;
  logic        pg, sel_ok;
  logic [7:0]  hold_lsb, hold_off;
  logic        hold_vld;
  logic [15:0] meas [NUM_MEAS];
  logic [7:0]  user [USER_N];

  logic [7:0]  mrel, uidx, cur;
  logic [15:0] mword;
  logic        in_meas, in_user, is_msb;

  assign mrel    = ptr - 8'(MEAS_BASE);
  assign uidx    = ptr - 8'(USER_LO);
  assign in_meas = pg && ptr >= 8'(MEAS_BASE) && ptr < 8'(MEAS_BASE + 2*NUM_MEAS);
  assign in_user = pg && ptr >= 8'(USER_LO) && ptr <= 8'(USER_HI);
  assign is_msb  = in_meas && !mrel[0];

  always_comb begin
    mword = '0;
    for (int i = 0; i < NUM_MEAS; i++)
      if (mrel[7:1] == 7'(i)) mword = meas[i];
  end

  always_comb begin
    cur = 8'(ptr * 8'd7) + (pg ? 8'h35 : 8'h00) + SEED;
    if (!pg) begin
      if (ptr == 8'd92) cur = DTYPE;
      if (ptr == 8'd63) cur = ID_CK_LO;
      if (ptr == 8'd95) cur = ID_CK_HI;
    end else begin
      if (ptr == 8'd95) cur = DG_CK;
      if (in_meas)
        cur = !mrel[0] ? mword[15:8] :
              (hold_vld && hold_off == ptr) ? hold_lsb : mword[7:0];
      if (in_user) cur = user[uidx[UW-1:0]];
    end
    if (!sel_ok) cur = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr      <= '0;
      pg       <= 1'b0;
      sel_ok   <= 1'b0;
      hold_lsb <= '0;
      hold_off <= '0;
      hold_vld <= 1'b0;
      rd_byte  <= '0;
      rd_valid <= 1'b0;
      for (int i = 0; i < USER_N; i++) user[i] <= '0;
    end else begin
      rd_valid <= rd_en && !xfer_start;
      if (xfer_start) begin
        pg       <= (dev_sel == DIAG_ADDR);
        sel_ok   <= (dev_sel == DIAG_ADDR) || (dev_sel == ID_ADDR);
        ptr      <= start_off;
        hold_vld <= 1'b0;
      end else if (rd_en) begin
        rd_byte <= cur;
        ptr     <= ptr + 8'd1;
        if (sel_ok && is_msb) begin
          hold_lsb <= mword[7:0];
          hold_off <= ptr + 8'd1;
          hold_vld <= 1'b1;
        end else if (in_meas) begin
          hold_vld <= 1'b0;
        end
      end else if (wr_en) begin
        if (sel_ok && in_user) user[uidx[UW-1:0]] <= wr_byte;
        ptr <= ptr + 8'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_MEAS; i++) meas[i] <= '0;
    end else if (meas_we) begin
      for (int i = 0; i < NUM_MEAS; i++)
        if (meas_idx == 3'(i)) meas[i] <= meas_word;
    end
  end
endmodule

module xcvr_mgmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_start,
  input logic       rd_en,
  input logic       wr_en,
  input logic       rd_valid,
  input logic [7:0] rd_byte,
  input logic [7:0] ptr,
  input logic       pg,
  input logic       sel_ok,
  input logic       hold_vld
);
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !xfer_start) |=> rd_valid);
  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == 8'd255 && (rd_en || wr_en) && !xfer_start) |=> ptr == 8'd0);
  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !xfer_start && ptr != 8'd255) |=> ptr == $past(ptr) + 8'd1);
  a_r11_bad_dev: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok && rd_en && !xfer_start) |=> rd_byte == 8'hFF);
  a_r6_hold_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ok && pg && rd_en && !xfer_start && ptr == 8'd96) |=> hold_vld);
endmodule

bind xcvr_mgmt_mem xcvr_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .rd_en(rd_en),
  .wr_en(wr_en), .rd_valid(rd_valid), .rd_byte(rd_byte), .ptr(ptr),
  .pg(pg), .sel_ok(sel_ok), .hold_vld(hold_vld)
);

// File: tb/xcvr_mgmt_mem_bench.sv
module xcvr_mgmt_mem_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] SEED = 8'h11;

  logic clk = 0, rst_n = 0;
  logic xfer_start = 0, rd_en = 0, wr_en = 0, meas_we = 0;
  logic [7:0] dev_sel = 0, start_off = 0, wr_byte = 0;
  logic [2:0] meas_idx = 0;
  logic [15:0] meas_word = 0;
  logic [7:0] rd_byte;
  logic rd_valid;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [15:0] m_model [5];
  logic [7:0]  u_model [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_mgmt_mem u_xcvr_mgmt_mem (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .dev_sel(dev_sel),
    .start_off(start_off), .rd_en(rd_en), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .meas_we(meas_we),
    .meas_idx(meas_idx), .meas_word(meas_word)
  );

  function automatic logic [7:0] base_b(input int pg, input int off);
    if (pg == 0 && off == 92) return 8'h60;
    return 8'((7*off + 'h35*pg + SEED) % 256);
  endfunction

  function automatic logic [7:0] sum_b(input int pg, input int lo, input int hi);
    int s = 0;
    for (int i = lo; i <= hi; i++) s += base_b(pg, i);
    return 8'(s % 256);
  endfunction

  function automatic logic [7:0] model_b(input int pg, input int off);
    if (pg == 0 && off == 63) return sum_b(0, 0, 62);
    if (pg == 0 && off == 95) return sum_b(0, 64, 94);
    if (pg == 1 && off == 95) return sum_b(1, 0, 94);
    if (pg == 1 && off >= 96 && off <= 105)
      return (off % 2 == 0) ? m_model[(off-96)/2][15:8] : m_model[(off-96)/2][7:0];
    if (pg == 1 && off >= 128 && off <= 247) return u_model[off];
    return base_b(pg, off);
  endfunction

  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R12 unexpected rd_valid actual=%02h expected=none", rd_byte);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_byte !== e) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", t, rd_byte, e);
        end
      end
    end
  end

  task automatic open_x(input logic [7:0] dev, input logic [7:0] off);
    dev_sel = dev; start_off = off; xfer_start = 1;
    @(negedge clk); xfer_start = 0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_byte = d; wr_en = 1; @(negedge clk); wr_en = 0;
  endtask

  task automatic mload(input logic [2:0] k, input logic [15:0] v);
    meas_idx = k; meas_word = v; meas_we = 1; @(negedge clk); meas_we = 0;
    if (k < 5) m_model[k] = v;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) m_model[i] = 16'h0000;
    for (int i = 0; i < 256; i++) u_model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (rd_valid !== 1'b0 || rd_byte !== 8'h00) begin
      failures++;
      $display("FAIL R12 reset actual=%0b/%02h expected=0/00", rd_valid, rd_byte);
    end
    // R11: before any transaction reads give FF
    rd(8'hFF, "R11 pre-transaction");

    // R1 identification bytes
    open_x(8'hA0, 8'd0);
    for (int i = 0; i < 4; i++) rd(model_b(0, i), "R1 id page");
    open_x(8'hA2, 8'd40);
    rd(model_b(1, 40), "R1 diag page");
    rd(model_b(1, 41), "R1 diag page");
    // R2
    open_x(8'hA0, 8'd92);
    rd(8'h60, "R2 diag type byte");
    // R3 sequential across checksum
    open_x(8'hA0, 8'd62);
    rd(model_b(0, 62), "R1 id page");
    rd(sum_b(0, 0, 62), "R3 id low checksum");
    open_x(8'hA0, 8'd95);
    rd(sum_b(0, 64, 94), "R3 id high checksum");
    // R4
    open_x(8'hA2, 8'd94);
    rd(model_b(1, 94), "R1 diag page");
    rd(sum_b(1, 0, 94), "R4 diag checksum");

    // R5 word order
    mload(3'd0, 16'h1234); mload(3'd1, 16'h5678); mload(3'd2, 16'h9ABC);
    mload(3'd3, 16'hDEF0); mload(3'd4, 16'h0F1E);
    open_x(8'hA2, 8'd96);
    for (int i = 96; i <= 105; i++) rd(model_b(1, i), "R5 measurement words");

    // R6 snapshot against a mid-pair update
    mload(3'd0, 16'hA1B2);
    open_x(8'hA2, 8'd96);
    rd(8'hA1, "R6 msb");
    mload(3'd0, 16'hC3D4);
    rd(8'hB2, "R6 latched lsb");
    open_x(8'hA2, 8'd97);
    rd(8'hD4, "R6 live lsb fresh transaction");
    open_x(8'hA2, 8'd98);
    rd(8'h56, "R6 voltage msb");
    mload(3'd1, 16'hEEFF);
    rd(8'h78, "R6 voltage latched lsb");

    // R13 out-of-range index
    mload(3'd5, 16'hBEEF); mload(3'd7, 16'hBEEF);
    open_x(8'hA2, 8'd96);
    for (int i = 96; i <= 105; i++) rd(model_b(1, i), "R13 bad index ignored");

    // R7 user area, boundaries
    open_x(8'hA2, 8'd128);
    rd(8'h00, "R7 user reset value");
    open_x(8'hA2, 8'd128);
    wr(8'h5A); wr(8'hC3); u_model[128] = 8'h5A; u_model[129] = 8'hC3;
    open_x(8'hA2, 8'd246);
    wr(8'h11); wr(8'h22); u_model[246] = 8'h11; u_model[247] = 8'h22;
    open_x(8'hA2, 8'd128);
    rd(8'h5A, "R7 user 128"); rd(8'hC3, "R7 user 129");
    open_x(8'hA2, 8'd246);
    rd(8'h11, "R7 user 246"); rd(8'h22, "R7 user 247");

    // R8 read-only writes ignored
    open_x(8'hA0, 8'd10); wr(8'h00);
    open_x(8'hA2, 8'd127); wr(8'h77); wr(8'h77);
    open_x(8'hA2, 8'd248); wr(8'h99);
    open_x(8'hA2, 8'd100); wr(8'h00);
    open_x(8'hA0, 8'd10); rd(model_b(0, 10), "R8 id write ignored");
    open_x(8'hA2, 8'd127); rd(model_b(1, 127), "R8 offset 127 ignored");
    rd(8'h77, "R7 user 128 written by sequential write");
    u_model[128] = 8'h77;
    open_x(8'hA2, 8'd248); rd(model_b(1, 248), "R8 offset 248 ignored");
    open_x(8'hA2, 8'd100); rd(model_b(1, 100), "R8 measurement write ignored");

    // R9 check bytes
    open_x(8'hA2, 8'd95); wr(8'h00);
    open_x(8'hA0, 8'd63); wr(8'hFF);
    open_x(8'hA0, 8'd95); wr(8'h01);
    open_x(8'hA2, 8'd95); rd(sum_b(1, 0, 94), "R9 diag checksum after write");
    open_x(8'hA0, 8'd63); rd(sum_b(0, 0, 62), "R9 id low checksum after write");
    open_x(8'hA0, 8'd95); rd(sum_b(0, 64, 94), "R9 id high checksum after write");

    // R10 wrap
    open_x(8'hA2, 8'd254);
    rd(model_b(1, 254), "R10 wrap 254"); rd(model_b(1, 255), "R10 wrap 255");
    rd(model_b(1, 0), "R10 wrap 0");
    open_x(8'hA0, 8'd255);
    rd(model_b(0, 255), "R10 id 255"); rd(model_b(0, 0), "R10 id wrap 0");

    // R11 bad device
    open_x(8'hA4, 8'd130);
    rd(8'hFF, "R11 bad device read");
    open_x(8'hA6, 8'd130); wr(8'h3C);
    open_x(8'hA2, 8'd130);
    rd(u_model[130], "R11 bad device write ignored");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R12 missing results actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule